// File: doc/BRIEF.md
# Edge and Gate Pulse Accumulator

This block counts activity on one external input. In event mode it increments a 16-bit count on every active edge of the input. The active edge is rising or falling, chosen by a control bit. In gated mode the input acts as a gate. While the gate is at its active level, the count advances once for every 64 system clocks. Two sticky flags record a count wrap and input activity. Each flag has its own interrupt enable. Software clears a flag by writing a one to its bit. A fast-clear option instead clears both flags on any access to the count.

The block also produces the tick enable that drives a separate timer counter. That tick comes from one of four sources: an external prescaler tick, the accumulator's own tick, or that tick divided by 256 or by 65536. While the accumulator is disabled, the prescaler tick is always used. Software reaches the registers through a synchronous bus with separate read and write strobes and a 2-bit address:

- Address 0 is control. The bits are: 0 enable, 1 gated mode, 2 invert (falling edge, or low gate), 4:3 timer clock select, 5 wrap interrupt enable, 6 input interrupt enable, 7 fast clear.
- Address 1 holds the flags.
- Address 2 holds the count.
- Address 3 reads as zero.

Top module: `pulse_acc`

## Requirements
- R1: In event mode with enable set, the count rises by one for each rising input edge when control bit 2 is 0, and for each falling edge when it is 1. The other edge has no effect.
- R2: In gated mode (control bit 1 = 1), the count rises by exactly one for each 64 consecutive clocks during which the input stays at its active level. The active level is high when bit 2 is 0 and low when bit 2 is 1.
- R3: The wrap flag (flag register bit 1) sets when the count steps from 0xFFFF to 0x0000 on an input event.
- R4: The input flag (flag register bit 0) sets on each counted edge in event mode. In gated mode it sets only on the trailing edge of the gate, never on the leading edge.
- R5: Writing the flag register clears each flag whose bit is written as 1. A flag whose bit is written as 0 keeps its value.
- R6: With control bit 7 set, any read or write of the count register clears both flags. With bit 7 clear, such an access leaves the flags unchanged.
- R7: The wrap interrupt output equals the wrap flag ANDed with control bit 5. The input interrupt output equals the input flag ANDed with control bit 6.
- R8: With enable set, the timer tick follows control bits 4:3. The settings are 00 for the prescaler tick, 01 for each accumulator tick, 10 for one tick per 256 accumulator ticks, and 11 for one tick per 65536 accumulator ticks. A new select applies from the cycle after the write.
- R9: With enable clear, the timer tick equals the prescaler tick whatever bits 4:3 hold, and the count does not change except by a bus write.
- R10: After reset, control, flags, count and both interrupts are 0. Flag register bits 15:2 always read as 0.
- R11: A write to the count register loads the written value, and the count reads back the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | External input, asynchronous |
| presc_tick | input | 1 | Prescaler tick, one-cycle pulses |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, same cycle |
| irq_wrap | output | 1 | Wrap interrupt request |
| irq_input | output | 1 | Input interrupt request |
| tmr_tick | output | 1 | Tick enable for the external timer counter |

## Verification
The assertions assume the following about the inputs:
- The bus never raises both strobes in one cycle.
- The prescaler tick is a single-cycle pulse.
- The input holds each level long enough to pass the two-stage synchronizer.

The stimulus holds every input level for at least two clocks and issues one bus access at a time. It changes the control register only while the input is idle. Gate windows are exact multiples of 64 clocks, so the gated count is exact whatever the phase of the free-running divider.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_FLAG = 2'd1,
        REG_CNT  = 2'd2,
        REG_RSVD = 2'd3
    } pa_reg_e;

    typedef enum logic [1:0] {
        CSEL_PRESC  = 2'd0,
        CSEL_ACC    = 2'd1,
        CSEL_ACC_LO = 2'd2,
        CSEL_ACC_HI = 2'd3
    } csel_e;

    // control register, MSB first: bit 7 fast_clr ... bit 0 en
    typedef struct packed {
        logic  fast_clr;
        logic  edge_ie;
        logic  wrap_ie;
        csel_e csel;
        logic  inv;
        logic  gated;
        logic  en;
    } ctrl_t;

    localparam int FLAG_EDGE_BIT = 0;
    localparam int FLAG_WRAP_BIT = 1;

endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/pa_gate_div.sv
module pa_gate_div #(
    parameter int BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [BITS-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = &cnt_q;
endmodule

// File: rtl/pa_clk_mux.sv
module pa_clk_mux
    import pa_pkg::*;
(
    input  logic  en,
    input  csel_e csel,
    input  logic  presc_tick,
    input  logic  acc_tick,
    input  logic  div_lo_tick,
    input  logic  div_hi_tick,
    output logic  tmr_tick
);
    always_comb begin
        if (!en) begin
            tmr_tick = presc_tick;
        end else begin
            unique case (csel)
                CSEL_PRESC:  tmr_tick = presc_tick;
                CSEL_ACC:    tmr_tick = acc_tick;
                CSEL_ACC_LO: tmr_tick = div_lo_tick;
                CSEL_ACC_HI: tmr_tick = div_hi_tick;
                default:     tmr_tick = presc_tick;
            endcase
        end
    end
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
    import pa_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int DATA_W        = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int GATE_DIV_BITS = 6,
    parameter int DIV_LO_BITS   = 8,
    parameter int DIV_HI_BITS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              presc_tick,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_wrap,
    output logic              irq_input,
    output logic              tmr_tick
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t                  ctrl;
        logic                   wrap;
        logic                   edg;
        logic [CNT_W-1:0]       cnt;
        logic [DIV_HI_BITS-1:0] div;
    } state_t;

    state_t st_d, st_q;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap_q;
    logic             edge_q;

    logic in_level, in_rise, in_fall;
    logic gate_tick;
    logic acc_tick, div_lo_tick, div_hi_tick;
    logic ev_edge, gate_act, gate_trail;
    logic wr_ctrl, wr_flag, wr_cnt, cnt_access;
    logic wrap_set, edge_set, wrap_clr, edge_clr;

    assign ctrl_q = st_q.ctrl;
    assign cnt_q  = st_q.cnt;
    assign wrap_q = st_q.wrap;
    assign edge_q = st_q.edg;

    pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_in),
        .level (in_level),
        .rise  (in_rise),
        .fall  (in_fall)
    );

    pa_gate_div #(.BITS(GATE_DIV_BITS)) u_gdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (gate_tick)
    );

    // event and gate decoding
    always_comb begin
        ev_edge    = ctrl_q.inv ? in_fall : in_rise;
        gate_act   = in_level ^ ctrl_q.inv;
        gate_trail = ctrl_q.inv ? in_rise : in_fall;
        acc_tick   = ctrl_q.en & (ctrl_q.gated ? (gate_act & gate_tick) : ev_edge);
        div_lo_tick = acc_tick & (&st_q.div[DIV_LO_BITS-1:0]);
        div_hi_tick = acc_tick & (&st_q.div);
    end

    // bus decoding
    always_comb begin
        wr_ctrl    = bus_wr && (bus_addr == REG_CTRL);
        wr_flag    = bus_wr && (bus_addr == REG_FLAG);
        wr_cnt     = bus_wr && (bus_addr == REG_CNT);
        cnt_access = (bus_wr || bus_rd) && (bus_addr == REG_CNT);
    end

    // next state
    always_comb begin
        st_d = st_q;

        wrap_set = acc_tick && !wr_cnt && (&cnt_q);
        edge_set = ctrl_q.en && (ctrl_q.gated ? gate_trail : ev_edge);
        wrap_clr = (wr_flag && bus_wdata[FLAG_WRAP_BIT]) || (ctrl_q.fast_clr && cnt_access);
        edge_clr = (wr_flag && bus_wdata[FLAG_EDGE_BIT]) || (ctrl_q.fast_clr && cnt_access);

        if (wr_ctrl) begin
            st_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end

        if (wr_cnt) begin
            st_d.cnt = bus_wdata[CNT_W-1:0];
        end else if (acc_tick) begin
            st_d.cnt = cnt_q + 1'b1;
        end

        if (acc_tick) begin
            st_d.div = st_q.div + 1'b1;
        end

        // a new event wins over a clear in the same cycle
        st_d.wrap = (wrap_q && !wrap_clr) || wrap_set;
        st_d.edg  = (edge_q && !edge_clr) || edge_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            REG_FLAG: begin
                bus_rdata[FLAG_WRAP_BIT] = wrap_q;
                bus_rdata[FLAG_EDGE_BIT] = edge_q;
            end
            REG_CNT:  bus_rdata[CNT_W-1:0] = cnt_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_wrap  = wrap_q & ctrl_q.wrap_ie;
    assign irq_input = edge_q & ctrl_q.edge_ie;

    pa_clk_mux u_mux (
        .en          (ctrl_q.en),
        .csel        (ctrl_q.csel),
        .presc_tick  (presc_tick),
        .acc_tick    (acc_tick),
        .div_lo_tick (div_lo_tick),
        .div_hi_tick (div_hi_tick),
        .tmr_tick    (tmr_tick)
    );
endmodule

// File: rtl/pa_checker.sv
module pa_checker
    import pa_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  cnt,
    input logic              wrap_flag,
    input logic              edge_flag,
    input logic              acc_tick,
    input logic              presc_tick,
    input logic              tmr_tick,
    input logic              irq_wrap,
    input logic              irq_input,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata
);
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == REG_CNT);

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt) && acc_tick && !cnt_wr) |=> wrap_flag); // R3

    AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_FLAG && !bus_wdata[FLAG_EDGE_BIT] && edge_flag) |=> edge_flag); // R5

    AST_WRAP_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.wrap_ie |-> !irq_wrap); // R7

    AST_INPUT_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.edge_ie |-> !irq_input); // R7

    AST_SEL_FROM_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.csel != CSEL_PRESC && tmr_tick) |-> acc_tick); // R8

    AST_OFF_USES_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> (tmr_tick == presc_tick)); // R9

    AST_OFF_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !cnt_wr) |=> $stable(cnt)); // R9

    AST_FLAG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_FLAG) |-> (bus_rdata[DATA_W-1:2] == '0)); // R10
endmodule

bind pulse_acc pa_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl_q),
    .cnt        (cnt_q),
    .wrap_flag  (wrap_q),
    .edge_flag  (edge_q),
    .acc_tick   (acc_tick),
    .presc_tick (presc_tick),
    .tmr_tick   (tmr_tick),
    .irq_wrap   (irq_wrap),
    .irq_input  (irq_input),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata)
);

// File: tb/pulse_acc_test.sv
`timescale 1ns/1ps
module pulse_acc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        presc_tick = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq_wrap, irq_input, tmr_tick;

    always #2 clk = ~clk;

    pulse_acc uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .presc_tick (presc_tick),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_wrap   (irq_wrap),
        .irq_input  (irq_input),
        .tmr_tick   (tmr_tick)
    );

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        int          kind;   // 0 read data, 1 wrap irq, 2 input irq
        logic [15:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor, samples mid-cycle after the driver has set up
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {15'd0, irq_wrap};
                default: act = {15'd0, irq_input};
            endcase
            check(it.tag, act, it.exp);
        end
    end

    // prescaler tick every 4 clocks
    int pc = 0;
    always @(negedge clk) begin
        pc <= (pc + 1) % 4;
        presc_tick <= (pc == 3);
    end

    // tick window counters
    logic cnt_on = 1'b0;
    int tick_n = 0;
    int presc_n = 0;
    always @(negedge clk) begin
        #1;
        if (cnt_on) begin
            tick_n  += int'(tmr_tick);
            presc_n += int'(presc_tick);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_expect(logic [1:0] a, logic [15:0] exp, string tag);
        sb_item_t it;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        it.kind = 0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic irq_expect(int kind, logic e, string tag);
        sb_item_t it;
        @(negedge clk);
        it.kind = kind; it.exp = {15'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pin_in = 1'b1;
            wait_cyc(2);
            pin_in = 1'b0;
            wait_cyc(2);
        end
        wait_cyc(6);
    endtask

    task automatic win_start();
        @(negedge clk);
        tick_n = 0; presc_n = 0; cnt_on = 1'b1;
    endtask

    task automatic win_stop();
        @(negedge clk);
        cnt_on = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #800000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R10 reset state
        read_expect(2'd0, 16'h0000, "R10 ctrl reset");
        read_expect(2'd1, 16'h0000, "R10 flags reset");
        read_expect(2'd2, 16'h0000, "R10 count reset");
        irq_expect(1, 1'b0, "R10 wrap irq reset");
        irq_expect(2, 1'b0, "R10 input irq reset");

        // R9 disabled: prescaler tick despite select 01, no counting
        bus_write(2'd0, 16'h0008);
        win_start();
        pulses(5);
        wait_cyc(60);
        win_stop();
        check("R9 disabled tick follows prescaler", 16'(tick_n), 16'(presc_n));
        check("R9 prescaler ticks seen", 16'(presc_n > 10), 16'd1);
        read_expect(2'd2, 16'h0000, "R9 disabled count holds");

        // R1 rising edges, R8 select 01, R4 event flag
        bus_write(2'd0, 16'h0009);
        win_start();
        pulses(10);
        win_stop();
        check("R8 select 01 one tick per edge", 16'(tick_n), 16'd10);
        read_expect(2'd2, 16'd10, "R1 rising edge count");
        read_expect(2'd1, 16'h0001, "R4 event flag set");

        // R1 falling edge selection
        bus_write(2'd0, 16'h000D);
        bus_write(2'd2, 16'h0000);
        bus_write(2'd1, 16'h0003);
        @(negedge clk); pin_in = 1'b1;
        wait_cyc(6);
        read_expect(2'd2, 16'h0000, "R1 rising ignored when inverted");
        @(negedge clk); pin_in = 1'b0;
        wait_cyc(6);
        read_expect(2'd2, 16'h0001, "R1 falling edge counted");

        // R3 wrap, R7 interrupt gating
        bus_write(2'd0, 16'h0021);
        bus_write(2'd1, 16'h0003);
        bus_write(2'd2, 16'hFFFE);
        pulses(1);
        read_expect(2'd2, 16'hFFFF, "R3 count at max");
        read_expect(2'd1, 16'h0001, "R3 no wrap before overflow");
        irq_expect(1, 1'b0, "R7 wrap irq low");
        pulses(1);
        read_expect(2'd2, 16'h0000, "R3 count wrapped");
        read_expect(2'd1, 16'h0003, "R3 wrap flag set");
        irq_expect(1, 1'b1, "R7 wrap irq enabled");
        irq_expect(2, 1'b0, "R7 input irq masked");

        // R5 write one to clear
        bus_write(2'd1, 16'h0002);
        read_expect(2'd1, 16'h0001, "R5 clear wrap keeps input flag");
        irq_expect(1, 1'b0, "R7 wrap irq after clear");
        bus_write(2'd1, 16'h0000);
        read_expect(2'd1, 16'h0001, "R5 zero write no effect");
        bus_write(2'd1, 16'h0001);
        read_expect(2'd1, 16'h0000, "R5 clear input flag");

        // R6 fast clear
        pulses(1);
        read_expect(2'd2, 16'h0001, "R6 count read fast off");
        read_expect(2'd1, 16'h0001, "R6 flags kept fast off");
        bus_write(2'd0, 16'h00A1);
        read_expect(2'd2, 16'h0001, "R6 count read fast on");
        read_expect(2'd1, 16'h0000, "R6 read clears flags");
        pulses(1);
        read_expect(2'd1, 16'h0001, "R6 flag set again");
        bus_write(2'd2, 16'h0007);
        read_expect(2'd1, 16'h0000, "R6 write clears flags");
        read_expect(2'd2, 16'h0007, "R11 count load");

        // R7 input interrupt
        bus_write(2'd0, 16'h0041);
        pulses(1);
        irq_expect(2, 1'b1, "R7 input irq enabled");
        irq_expect(1, 1'b0, "R7 wrap irq masked");

        // R8 divide by 256 and 65536
        bus_write(2'd0, 16'h0011);
        win_start();
        pulses(256);
        win_stop();
        check("R8 select 10 one tick per 256", 16'(tick_n), 16'd1);
        bus_write(2'd0, 16'h0019);
        win_start();
        pulses(20);
        win_stop();
        check("R8 select 11 no tick below 65536", 16'(tick_n), 16'd0);
        bus_write(2'd0, 16'h0001);
        win_start();
        wait_cyc(100);
        win_stop();
        check("R8 select 00 prescaler", 16'(tick_n), 16'(presc_n));

        // R2 gated accumulation, R4 trailing edge flag
        bus_write(2'd0, 16'h0003);
        bus_write(2'd2, 16'h0000);
        bus_write(2'd1, 16'h0003);
        @(negedge clk); pin_in = 1'b1;
        wait_cyc(20);
        read_expect(2'd1, 16'h0000, "R4 no flag on leading gate edge");
        wait_cyc(640 - 22);
        pin_in = 1'b0;
        wait_cyc(6);
        read_expect(2'd2, 16'd10, "R2 gated count 640 clocks");
        read_expect(2'd1, 16'h0001, "R4 trailing gate edge flag");

        // R11 load and R10 upper flag bits
        bus_write(2'd2, 16'h1234);
        read_expect(2'd2, 16'h1234, "R11 count readback");
        bus_write(2'd1, 16'hFFFC);
        read_expect(2'd1, 16'h0001, "R10 upper flag bits zero");

        wait_cyc(4);
        finish_run();
    end
endmodule